// File: doc/BRIEF.md
# Security Access Filter for a Single Bus Slave

This block sits between a bus requester and one slave that carries no notion of secure or non-secure traffic. Each request comes with a non-secure flag, a direction and a privilege flag. The filter looks up a programmable permission set to decide whether the access may reach the slave. A permitted access is forwarded to the slave one clock later. A forbidden access never reaches the slave. It is answered in one of two ways, chosen by software. In quiet mode, writes vanish and reads return zero with a normal response. In fault mode, an error response is returned, which the requester treats as an abort.

A small configuration port holds the permission bits, the blocking mode and a sticky record of the first offending access. Only secure configuration writes can change these registers, so non-secure software cannot open its own path to the slave. Two build options are available. One widens the permission set so that privileged and user accesses are judged separately. The other lets every secure access through whatever its bits say.

Top module: `sec_access_filter`

## Requirements
- R1: A permitted request (req_valid high) appears at the slave port on the next clock with slv_sel high and the same address, direction and write data.
- R2: The decision uses the permission bit at index {ns, write}: bit 0 secure read, bit 1 secure write, bit 2 non-secure read, bit 3 non-secure write. A clear bit blocks the access, and a blocked access never raises slv_sel.
- R3: In quiet mode (mode register bit 0 = 0), a blocked write gets a normal response and leaves the slave contents unchanged.
- R4: In quiet mode, a blocked read gets rsp_err low and rsp_rdata all zero.
- R5: In fault mode (mode register bit 0 = 1), a blocked access gets rsp_err high and rsp_rdata zero. The mode is taken at the cycle the request is presented.
- R6: Every request gets exactly one rsp_valid pulse two clocks after it is presented. For a permitted access rsp_err is low; a permitted read returns the slave data and a permitted write returns zero data.
- R7: Configuration address 0 holds the permission bits and address 1 holds the mode. Only a configuration write with cfg_ns low takes effect; a non-secure write is ignored. Reads are allowed with either cfg_ns value. The read data appears on the next clock and is zero in cycles with no read.
- R8: The first blocked access is recorded at configuration address 2 (bit 0 valid, bit 1 write, bit 2 ns, bit 3 user) and address 3 (its address). Later blocked accesses do not overwrite the record. If a clear and a blocked access fall in the same cycle, the new access is recorded.
- R9: A secure configuration write to address 2 with bit 0 set clears the record; the same write from a non-secure source is ignored.
- R10: With PRIV_SPLIT = 1, the permission set is 8 bits wide: bits [3:0] judge privileged accesses (req_priv = 1) and bits [7:4] judge user accesses, each nibble in the R2 order.
- R11: With SECURE_ALWAYS = 1, every secure access is forwarded regardless of its permission bit.
- R12: After reset the permission bits equal PERM_RST (default 0, everything blocked), the mode is quiet, the record is clear, and slv_sel, rsp_valid and cfg_rdata are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ns | input | 1 | 1 = non-secure request |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | DATA_W | Response read data |
| slv_sel | output | 1 | Slave select |
| slv_write | output | 1 | Slave direction |
| slv_addr | output | ADDR_W | Slave address |
| slv_wdata | output | DATA_W | Slave write data |
| slv_rdata | input | DATA_W | Slave read data, valid while selected |
| cfg_valid | input | 1 | Configuration access present |
| cfg_write | input | 1 | Configuration write |
| cfg_ns | input | 1 | Configuration access is non-secure |
| cfg_addr | input | 2 | Configuration register index |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Configuration read data |

## Verification
A wrong permission bit or index order shows up on slv_sel on the very next clock. It then shows up on the response strobe, error flag or data two clocks after the request. A corrupted mode bit is seen as a flipped rsp_err on the next blocked access. A lost or overwritten violation record is only seen when software reads addresses 2 and 3, one clock after the read. For that reason the reference model compares every configuration read, and the randomised phase reads the record often.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;
  localparam logic [1:0] ADR_PERM  = 2'd0;
  localparam logic [1:0] ADR_MODE  = 2'd1;
  localparam logic [1:0] ADR_STAT  = 2'd2;
  localparam logic [1:0] ADR_VADDR = 2'd3;

  typedef struct packed {
    logic user;
    logic ns;
    logic write;
    logic valid;
  } viol_rec_t;
endpackage

// File: rtl/sec_filter_check.sv
module sec_filter_check #(
  parameter int PRIV_SPLIT    = 1,
  parameter int SECURE_ALWAYS = 0,
  parameter int PERM_W        = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ns,
  input  logic              req_priv,
  input  logic [PERM_W-1:0] perm,
  output logic              allow,
  output logic              viol
);
  localparam int IDX_W = (PRIV_SPLIT != 0) ? 3 : 2;

  logic [IDX_W-1:0] idx;

  generate
    if (PRIV_SPLIT != 0) begin : g_split
      assign idx = {~req_priv, req_ns, req_write};
    end else begin : g_flat
      logic unused_priv;
      assign unused_priv = req_priv;
      assign idx = {req_ns, req_write};
    end
  endgenerate

  logic sec_bypass;
  assign sec_bypass = (SECURE_ALWAYS != 0) && !req_ns;
  assign allow      = perm[idx] | sec_bypass;
  assign viol       = req_valid & ~allow;
endmodule

// File: rtl/sec_filter_regs.sv
module sec_filter_regs
  import sec_filter_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          PERM_W   = 8,
  parameter logic [7:0]  PERM_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_ns,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              viol,
  input  logic              req_write,
  input  logic              req_ns,
  input  logic              req_priv,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [PERM_W-1:0] perm,
  output logic              err_mode,
  output logic              stat_valid,
  output logic              stat_clr,
  output logic [ADDR_W-1:0] stat_vaddr
);
  viol_rec_t rec;
  logic      sec_wr;
  logic [DATA_W-1:0] rd_mux;
  logic      unused_wdata;

  assign unused_wdata = ^cfg_wdata[DATA_W-1:PERM_W];
  assign sec_wr     = cfg_valid & cfg_write & ~cfg_ns;
  assign stat_clr   = sec_wr && (cfg_addr == ADR_STAT) && cfg_wdata[0];
  assign stat_valid = rec.valid;

  always_comb begin
    case (cfg_addr)
      ADR_PERM:  rd_mux = {{(DATA_W-PERM_W){1'b0}}, perm};
      ADR_MODE:  rd_mux = {{(DATA_W-1){1'b0}}, err_mode};
      ADR_STAT:  rd_mux = {{(DATA_W-4){1'b0}}, rec};
      default:   rd_mux = {{(DATA_W-ADDR_W){1'b0}}, stat_vaddr};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perm       <= PERM_RST[PERM_W-1:0];
      err_mode   <= 1'b0;
      rec        <= '0;
      stat_vaddr <= '0;
      cfg_rdata  <= '0;
    end else begin
      if (sec_wr && cfg_addr == ADR_PERM) perm <= cfg_wdata[PERM_W-1:0];
      if (sec_wr && cfg_addr == ADR_MODE) err_mode <= cfg_wdata[0];
      if (viol && (!rec.valid || stat_clr)) begin
        rec.valid  <= 1'b1;
        rec.write  <= req_write;
        rec.ns     <= req_ns;
        rec.user   <= ~req_priv;
        stat_vaddr <= req_addr;
      end else if (stat_clr) begin
        rec        <= '0;
        stat_vaddr <= '0;
      end
      cfg_rdata <= (cfg_valid && !cfg_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sec_filter_path.sv
module sec_filter_path #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              allow,
  input  logic              err_mode,
  output logic              slv_sel,
  output logic              slv_write,
  output logic [ADDR_W-1:0] slv_addr,
  output logic [DATA_W-1:0] slv_wdata,
  input  logic [DATA_W-1:0] slv_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic s1_valid, s1_block, s1_err_mode, s1_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      slv_sel     <= 1'b0;
      slv_write   <= 1'b0;
      slv_addr    <= '0;
      slv_wdata   <= '0;
      s1_valid    <= 1'b0;
      s1_block    <= 1'b0;
      s1_err_mode <= 1'b0;
      s1_write    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      slv_sel     <= req_valid & allow;
      slv_write   <= req_write;
      slv_addr    <= req_addr;
      slv_wdata   <= req_wdata;
      s1_valid    <= req_valid;
      s1_block    <= req_valid & ~allow;
      s1_err_mode <= err_mode;
      s1_write    <= req_write;
      rsp_valid   <= s1_valid;
      rsp_err     <= s1_valid & s1_block & s1_err_mode;
      rsp_rdata   <= (s1_valid && !s1_block && !s1_write) ? slv_rdata : '0;
    end
  end
endmodule

// File: rtl/sec_access_filter.sv
module sec_access_filter #(
  parameter int         ADDR_W        = 12,
  parameter int         DATA_W        = 32,
  parameter int         PRIV_SPLIT    = 1,
  parameter int         SECURE_ALWAYS = 0,
  parameter logic [7:0] PERM_RST      = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ns,
  input  logic              req_priv,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              slv_sel,
  output logic              slv_write,
  output logic [ADDR_W-1:0] slv_addr,
  output logic [DATA_W-1:0] slv_wdata,
  input  logic [DATA_W-1:0] slv_rdata,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_ns,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata
);
  localparam int IDX_W  = (PRIV_SPLIT != 0) ? 3 : 2;
  localparam int PERM_W = 1 << IDX_W;

  logic              allow, viol, err_mode, stat_valid, stat_clr;
  logic [PERM_W-1:0] perm_q;
  logic [ADDR_W-1:0] stat_vaddr;

  sec_filter_check #(
    .PRIV_SPLIT(PRIV_SPLIT), .SECURE_ALWAYS(SECURE_ALWAYS), .PERM_W(PERM_W)
  ) u_check (
    .req_valid(req_valid), .req_write(req_write), .req_ns(req_ns),
    .req_priv(req_priv), .perm(perm_q), .allow(allow), .viol(viol)
  );

  sec_filter_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERM_W(PERM_W), .PERM_RST(PERM_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_ns(cfg_ns), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .viol(viol), .req_write(req_write),
    .req_ns(req_ns), .req_priv(req_priv), .req_addr(req_addr),
    .perm(perm_q), .err_mode(err_mode), .stat_valid(stat_valid),
    .stat_clr(stat_clr), .stat_vaddr(stat_vaddr)
  );

  sec_filter_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .allow(allow),
    .err_mode(err_mode), .slv_sel(slv_sel), .slv_write(slv_write),
    .slv_addr(slv_addr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sec_access_filter_chk.sv
module sec_access_filter_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PERM_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              viol,
  input logic              err_mode,
  input logic [PERM_W-1:0] perm,
  input logic              stat_valid,
  input logic              stat_clr,
  input logic [ADDR_W-1:0] stat_vaddr,
  input logic              slv_sel,
  input logic              slv_write,
  input logic [ADDR_W-1:0] slv_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              cfg_valid,
  input logic              cfg_write,
  input logic              cfg_ns
);
  p_pass_fwd_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && !viol |=> slv_sel && slv_addr == $past(req_addr) && slv_write == $past(req_write));

  p_block_no_sel_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && viol |=> !slv_sel);

  p_quiet_wr_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && viol && !err_mode && req_write |-> ##2 (rsp_valid && !rsp_err));

  p_quiet_rd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && viol && !err_mode && !req_write |-> ##2 (rsp_valid && !rsp_err && rsp_rdata == '0));

  p_fault_resp_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && viol && err_mode |-> ##2 (rsp_valid && rsp_err));

  p_rsp_timing_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 rsp_valid);

  p_perm_guard_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && cfg_write && cfg_ns |=> $stable(perm));

  p_rec_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    stat_valid && !stat_clr |=> stat_valid && $stable(stat_vaddr));
endmodule

bind sec_access_filter sec_access_filter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERM_W(PERM_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .viol(viol), .err_mode(err_mode), .perm(perm_q),
  .stat_valid(stat_valid), .stat_clr(stat_clr), .stat_vaddr(stat_vaddr),
  .slv_sel(slv_sel), .slv_write(slv_write), .slv_addr(slv_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_ns(cfg_ns)
);

// File: tb/sec_access_filter_bench.sv
`timescale 1ns/1ps
module sec_access_filter_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_ns = 0, req_priv = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          cfg_valid = 0, cfg_write = 0, cfg_ns = 0;
  logic [1:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;

  logic          rsp_valid, rsp_err, slv_sel, slv_write;
  logic [DW-1:0] rsp_rdata, slv_wdata, slv_rdata, cfg_rdata;
  logic [AW-1:0] slv_addr;

  logic          rsp_valid2, rsp_err2, slv_sel2, slv_write2;
  logic [DW-1:0] rsp_rdata2, slv_wdata2, cfg_rdata2;
  logic [AW-1:0] slv_addr2;

  sec_access_filter #(.ADDR_W(AW), .DATA_W(DW), .PRIV_SPLIT(1), .SECURE_ALWAYS(0)) u_sec_access_filter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_ns(req_ns),
    .req_priv(req_priv), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .slv_sel(slv_sel), .slv_write(slv_write),
    .slv_addr(slv_addr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .cfg_valid(cfg_valid),
    .cfg_write(cfg_write), .cfg_ns(cfg_ns), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata));

  sec_access_filter #(.ADDR_W(AW), .DATA_W(DW), .PRIV_SPLIT(0), .SECURE_ALWAYS(1)) u_sec_access_filter_sa (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_ns(req_ns),
    .req_priv(req_priv), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid2),
    .rsp_err(rsp_err2), .rsp_rdata(rsp_rdata2), .slv_sel(slv_sel2), .slv_write(slv_write2),
    .slv_addr(slv_addr2), .slv_wdata(slv_wdata2), .slv_rdata('0), .cfg_valid(cfg_valid),
    .cfg_write(cfg_write), .cfg_ns(cfg_ns), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata2));

  // Slave model behind the main filter
  logic [DW-1:0] smem [16];
  assign slv_rdata = (slv_sel && !slv_write) ? smem[slv_addr[3:0]] : 32'hA5A5_A5A5;
  always @(posedge clk) if (slv_sel && slv_write) smem[slv_addr[3:0]] <= slv_wdata;

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  logic [7:0]    m_perm, m_perm2_w;
  logic [3:0]    m_perm2;
  logic          m_mode, m_sv, m_sw, m_sns, m_su;
  logic [AW-1:0] m_vaddr;
  logic [DW-1:0] ref_mem [16];
  logic          ex_sel, ex_sel2, ex_swr;
  logic [AW-1:0] ex_saddr;
  logic [DW-1:0] ex_swdata;
  string         ex_sel_tag = "R1";
  logic          e1_v, e1_err, e2_v, e2_err;
  logic [DW-1:0] e1_d, e2_d, ex_cfg;
  string         e1_tag = "R6", e2_tag = "R6", ex_cfg_tag = "R7";
  string         tag_perm = "R12", tag_stat = "R12";

  initial for (int i = 0; i < 16; i++) begin smem[i] = '0; ref_mem[i] = '0; end

  always @(posedge clk) begin
    if (rst) begin
      m_perm = 8'h00; m_perm2 = 4'h0; m_mode = 0;
      m_sv = 0; m_sw = 0; m_sns = 0; m_su = 0; m_vaddr = '0;
      ex_sel = 0; ex_sel2 = 0; e1_v = 0; e1_err = 0; e1_d = '0;
      e2_v = 0; e2_err = 0; e2_d = '0; ex_cfg = '0;
    end else begin
      bit allow, allow2, viol, clr;
      allow  = m_perm[{~req_priv, req_ns, req_write}];
      allow2 = m_perm2[{req_ns, req_write}] | ~req_ns;
      viol   = req_valid && !allow;
      ex_sel    = req_valid && allow;
      ex_sel2   = req_valid && allow2;
      ex_saddr  = req_addr;
      ex_swr    = req_write;
      ex_swdata = req_wdata;
      ex_sel_tag = !req_priv ? "R10" : (allow ? "R1" : "R2");
      e2_v = e1_v; e2_err = e1_err; e2_d = e1_d; e2_tag = e1_tag;
      e1_v = req_valid; e1_err = 0; e1_d = '0; e1_tag = "R6";
      if (req_valid) begin
        if (allow) begin
          if (req_write) ref_mem[req_addr[3:0]] = req_wdata;
          else e1_d = ref_mem[req_addr[3:0]];
        end else begin
          e1_err = m_mode;
          e1_tag = m_mode ? "R5" : (req_write ? "R3" : "R4");
        end
      end
      ex_cfg = '0;
      ex_cfg_tag = (cfg_addr < 2) ? tag_perm : tag_stat;
      if (cfg_valid && !cfg_write) begin
        case (cfg_addr)
          2'd0: ex_cfg = {24'd0, m_perm};
          2'd1: ex_cfg = {31'd0, m_mode};
          2'd2: ex_cfg = {28'd0, m_su, m_sns, m_sw, m_sv};
          default: ex_cfg = {24'd0, m_vaddr};
        endcase
      end
      clr = cfg_valid && cfg_write && !cfg_ns && cfg_addr == 2'd2 && cfg_wdata[0];
      if (viol && (!m_sv || clr)) begin
        m_sv = 1; m_sw = req_write; m_sns = req_ns; m_su = !req_priv; m_vaddr = req_addr;
      end else if (clr) begin
        m_sv = 0; m_sw = 0; m_sns = 0; m_su = 0; m_vaddr = '0;
      end
      if (cfg_valid && cfg_write && !cfg_ns) begin
        m_perm2_w = cfg_wdata[7:0];
        if (cfg_addr == 2'd0) begin m_perm = cfg_wdata[7:0]; m_perm2 = m_perm2_w[3:0]; end
        if (cfg_addr == 2'd1) m_mode = cfg_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(slv_sel == ex_sel, ex_sel_tag, 64'(slv_sel), 64'(ex_sel));
      if (ex_sel && slv_sel) begin
        check(slv_addr == ex_saddr, "R1", 64'(slv_addr), 64'(ex_saddr));
        check(slv_write == ex_swr, "R1", 64'(slv_write), 64'(ex_swr));
        if (ex_swr) check(slv_wdata == ex_swdata, "R1", 64'(slv_wdata), 64'(ex_swdata));
      end
      check(rsp_valid == e2_v, "R6", 64'(rsp_valid), 64'(e2_v));
      if (e2_v) begin
        check(rsp_err == e2_err, e2_tag, 64'(rsp_err), 64'(e2_err));
        check(rsp_rdata == e2_d, e2_tag, 64'(rsp_rdata), 64'(e2_d));
      end
      check(cfg_rdata == ex_cfg, ex_cfg_tag, 64'(cfg_rdata), 64'(ex_cfg));
      check(slv_sel2 == ex_sel2, "R11", 64'(slv_sel2), 64'(ex_sel2));
    end
  end

  task automatic req(input bit w, input bit ns, input bit pr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_write = w; req_ns = ns; req_priv = pr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic cfg(input bit w, input bit ns, input logic [1:0] a, input logic [DW-1:0] d);
    cfg_valid = 1; cfg_write = w; cfg_ns = ns; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    check(slv_sel == 0, "R12", 64'(slv_sel), 0);
    check(rsp_valid == 0, "R12", 64'(rsp_valid), 0);
    check(cfg_rdata == 0, "R12", 64'(cfg_rdata), 0);
    cfg(0, 0, 2'd0, 0); cfg(0, 1, 2'd1, 0); cfg(0, 0, 2'd2, 0);
    req(1, 1, 1, 8'h05, 32'h1111_0000);           // blocked at reset: R12, R3
    idle(2);
    cfg(1, 0, 2'd2, 1); idle(1);
    tag_perm = "R7"; tag_stat = "R8";
    cfg(1, 0, 2'd0, 32'hFF);
    for (int i = 0; i < 4; i++) req(1, 0, 1, 8'(i), 32'hC0DE_0000 + i);
    for (int i = 0; i < 4; i++) req(0, 1, 0, 8'(i), 0);
    cfg(1, 0, 2'd0, 32'h03);
    cfg(1, 1, 2'd0, 32'hFF);                       // non-secure write ignored, R7
    cfg(0, 1, 2'd0, 0);
    req(1, 1, 1, 8'h02, 32'hBAD0_0002);            // quiet drop, R3
    req(0, 1, 1, 8'h02, 0);                        // quiet zero read, R4
    req(0, 0, 1, 8'h02, 0);                        // original data survives, R3
    cfg(0, 0, 2'd2, 0); cfg(0, 0, 2'd3, 0);
    req(0, 0, 0, 8'h01, 0);                        // user secure read blocked, R10
    cfg(1, 0, 2'd0, 32'h13);
    req(0, 0, 0, 8'h01, 0);                        // now permitted, R10
    cfg(0, 0, 2'd2, 0); cfg(0, 0, 2'd3, 0);
    tag_stat = "R9";
    cfg(1, 1, 2'd2, 1); cfg(0, 0, 2'd2, 0);
    cfg(1, 0, 2'd2, 1); cfg(0, 0, 2'd2, 0); cfg(0, 0, 2'd3, 0);
    tag_perm = "R7"; tag_stat = "R8";
    cfg(1, 0, 2'd1, 1);
    req(0, 1, 1, 8'h03, 0);                        // fault read, R5
    req(1, 1, 0, 8'h04, 32'h77);                   // fault write, R5
    cfg(0, 0, 2'd2, 0); cfg(0, 0, 2'd3, 0);
    // clear and violation in the same cycle: new one kept, R8
    req_valid = 1; req_write = 0; req_ns = 1; req_priv = 0; req_addr = 8'h09;
    cfg_valid = 1; cfg_write = 1; cfg_ns = 0; cfg_addr = 2'd2; cfg_wdata = 1;
    @(negedge clk);
    req_valid = 0; cfg_valid = 0; cfg_write = 0;
    cfg(0, 0, 2'd2, 0); cfg(0, 0, 2'd3, 0);
    // randomised mixed traffic
    for (int n = 0; n < 600; n++) begin
      req_valid = 1'($urandom); req_write = 1'($urandom); req_ns = 1'($urandom);
      req_priv = 1'($urandom); req_addr = 8'($urandom_range(0, 15)); req_wdata = $urandom;
      cfg_valid = ($urandom_range(0, 3) == 0); cfg_write = ($urandom_range(0, 3) == 0);
      cfg_ns = 1'($urandom); cfg_addr = 2'($urandom); cfg_wdata = $urandom;
      @(negedge clk);
    end
    req_valid = 0; cfg_valid = 0;
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule